// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the byte-wide arithmetic and logic unit of an accumulator-based 8-bit controller core. Each operation takes the accumulator byte, a second operand byte and the incoming carry, auxiliary-carry and overflow flags. It returns the result byte together with updated carry, auxiliary-carry, overflow and parity flags. The unit covers binary add and subtract with carry or borrow, increment and decrement, the bitwise operations, complement, clear, nibble swap, four rotate forms and the decimal-adjust step that repairs a packed BCD sum.

Operations enter through a valid/ready request port and leave through a valid/ready response port. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its result is held in a single output register until it is consumed by `out_valid` and `out_ready` being high together. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so the unit sustains one operation per cycle. While a result waits with `out_ready` low, `in_ready` is low and every response field stays frozen. Flags that an operation does not define are copied from the request's incoming flags. The core's flag register therefore stays outside the block.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) returns acc+opnd and op 1 (add with carry) returns acc+opnd+cy, both modulo 256. Carry is the carry out of bit 7.
- R2: Op 2 (subtract with borrow) returns acc-opnd-cy modulo 256. Carry is set when a borrow leaves bit 7. Auxiliary carry is set when a borrow leaves bit 3.
- R3: For ops 0, 1 and 2, overflow is set exactly when one, and only one, of the carries (borrows) out of bit 6 and out of bit 7 occurs.
- R4: For ops 0 and 1, auxiliary carry is the carry out of bit 3.
- R5: The parity output is 1 when the result byte holds an odd number of ones, for every op.
- R6: Op 3 (increment) and op 4 (decrement) wrap modulo 256 and pass carry, auxiliary carry and overflow through unchanged.
- R7: Op 5 (AND), op 6 (OR), op 7 (XOR), op 8 (complement acc), op 9 (clear to zero) and op 10 (swap acc nibbles) pass all three arithmetic flags through unchanged.
- R8: Op 11 rotates acc left and op 13 rotates it right, each without touching carry. Op 12 rotates left through carry (bit 7 to carry, carry to bit 0). Op 14 rotates right through carry (bit 0 to carry, carry to bit 7). Ops 12 and 14 leave auxiliary carry and overflow unchanged.
- R9: Op 15 (decimal adjust) adds 0x06 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the high nibble exceeds 9 or carry is set. Carry ends set if it was set or if either addition overflows bit 7. Auxiliary carry and overflow pass through.
- R10: A request accepted at a clock edge shows its result with `out_valid` high right after that edge. With no new request, `out_valid` falls after the edge on which the result is consumed.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all response fields hold their values.
- R12: While reset is asserted and after it is released, `out_valid` is low and `in_ready` is high until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code, 0 to 15 as listed in the requirements |
| in_acc | input | 8 | Accumulator operand |
| in_opnd | input | 8 | Second operand |
| in_cy | input | 1 | Incoming carry flag |
| in_ac | input | 1 | Incoming auxiliary-carry flag |
| in_ov | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| out_res | output | 8 | Result byte |
| out_cy | output | 1 | Resulting carry flag |
| out_ac | output | 1 | Resulting auxiliary-carry flag |
| out_ov | output | 1 | Resulting overflow flag |
| out_par | output | 1 | Parity of the result byte |

## Verification
Every response field comes from the output register. A result is therefore due exactly one rising edge after the edge that accepts its request. Nothing about it is visible in the half cycle before that edge. The bench drives each request at a falling edge and lets one rising edge accept it. It reads the result and flags at the following falling edge, and it also checks that `out_valid` is still low before the accepting edge. For back-pressure, the bench holds `out_ready` low for several cycles and reads the frozen response at falling edges. It then releases `out_ready` and expects the queued request's result after the single edge that both drains and refills the register.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_CLR  = 4'd9,
    OP_SWAP = 4'd10,
    OP_RL   = 4'd11,
    OP_RLC  = 4'd12,
    OP_RR   = 4'd13,
    OP_RRC  = 4'd14,
    OP_DA   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
// Ripple adder/subtractor with half, top-minus-one and top carries exposed.
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int HALF = W / 2;

  logic [W:0]   chain;
  logic [W-1:0] b_eff;

  // Subtraction runs as a + ~b + ~borrow_in; each carry is the inverse of a borrow.
  assign b_eff    = sub ? ~b : b;
  assign chain[0] = sub ? ~cin : cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
  end

  assign cy_o = chain[W] ^ sub;
  assign ac_o = chain[HALF] ^ sub;
  // Inverting both carries for subtraction leaves their difference unchanged.
  assign ov_o = chain[W] ^ chain[W-1];
endmodule

// File: rtl/acc_alu_unary.sv
// Increment, decrement, bitwise, nibble swap and rotate paths.
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cy_o
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    res  = a;
    cy_o = cin;
    unique case (op)
      OP_INC:  res = a + ONE;
      OP_DEC:  res = a - ONE;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      OP_CLR:  res = '0;
      OP_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RLC: begin
        res  = {a[W-2:0], cin};
        cy_o = a[W-1];
      end
      OP_RRC: begin
        res  = {cin, a[W-1:1]};
        cy_o = a[0];
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
// Two-step packed BCD correction of a byte after a binary addition.
module acc_alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         acin,
  output logic [W-1:0] res,
  output logic         cy_o
);
  localparam int HALF = W / 2;
  localparam logic [HALF-1:0] NINE = HALF'(9);
  localparam logic [W:0] LO_FIX = (W+1)'(6);
  localparam logic [W:0] HI_FIX = (W+1)'(6) << HALF;

  logic         lo_need, hi_need;
  logic [W:0]   step1, step2;
  logic         cy_mid;

  always_comb begin
    lo_need = (a[HALF-1:0] > NINE) | acin;
    step1   = {1'b0, a} + (lo_need ? LO_FIX : '0);
    cy_mid  = cin | step1[W];
    hi_need = (step1[W-1:HALF] > NINE) | cy_mid;
    step2   = {1'b0, step1[W-1:0]} + (hi_need ? HI_FIX : '0);
    res     = step2[W-1:0];
    cy_o    = cy_mid | step2[W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0] in_acc,
  input  logic [DW-1:0] in_opnd,
  input  logic          in_cy,
  input  logic          in_ac,
  input  logic          in_ov,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_cy,
  output logic          out_ac,
  output logic          out_ov,
  output logic          out_par
);
  alu_op_e      op;
  logic         is_sub, is_arith;
  logic         add_cin;
  logic [DW-1:0] add_sum, un_res, da_res;
  logic         add_cy, add_ac, add_ov, un_cy, da_cy;
  logic [DW-1:0] nxt_res;
  alu_flags_t   nxt_flg, res_flg;
  logic         in_fire;
  logic [DW-1:0] res_q;

  assign op       = alu_op_e'(in_op);
  assign is_sub   = (op == OP_SUBB);
  assign is_arith = (op == OP_ADD) | (op == OP_ADDC) | is_sub;
  assign add_cin  = (op == OP_ADDC || is_sub) ? in_cy : 1'b0;

  acc_alu_addsub #(.W(DW)) u_addsub (
    .sub (is_sub),
    .a   (in_acc),
    .b   (in_opnd),
    .cin (add_cin),
    .sum (add_sum),
    .cy_o(add_cy),
    .ac_o(add_ac),
    .ov_o(add_ov)
  );

  acc_alu_unary #(.W(DW)) u_unary (
    .op  (op),
    .a   (in_acc),
    .b   (in_opnd),
    .cin (in_cy),
    .res (un_res),
    .cy_o(un_cy)
  );

  acc_alu_decadj #(.W(DW)) u_decadj (
    .a   (in_acc),
    .cin (in_cy),
    .acin(in_ac),
    .res (da_res),
    .cy_o(da_cy)
  );

  always_comb begin
    nxt_flg = '{cy: in_cy, ac: in_ac, ov: in_ov};
    if (is_arith) begin
      nxt_res = add_sum;
      nxt_flg = '{cy: add_cy, ac: add_ac, ov: add_ov};
    end else if (op == OP_DA) begin
      nxt_res    = da_res;
      nxt_flg.cy = da_cy;
    end else begin
      nxt_res    = un_res;
      nxt_flg.cy = un_cy;
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign in_fire  = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      res_flg   <= '0;
      out_par   <= 1'b0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        res_q     <= nxt_res;
        res_flg   <= nxt_flg;
        out_par   <= ^nxt_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_res = res_q;
  assign out_cy  = res_flg.cy;
  assign out_ac  = res_flg.ac;
  assign out_ov  = res_flg.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [OPW-1:0] in_op,
  input logic [DW-1:0] in_acc,
  input logic [DW-1:0] in_opnd,
  input logic          in_cy,
  input logic          in_ac,
  input logic          in_ov,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_res,
  input logic          out_cy,
  input logic          out_ac,
  input logic          out_ov,
  input logic          out_par
);
  logic take, incdec, keeps_all, rot_c;

  assign take      = in_valid & in_ready;
  assign incdec    = (in_op == OP_INC) | (in_op == OP_DEC);
  assign keeps_all = (in_op >= OP_AND) & (in_op <= OP_SWAP)
                   | (in_op == OP_RL) | (in_op == OP_RR);
  assign rot_c     = (in_op == OP_RLC);

  p_idle_reset_r12: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_stall_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_cy)
      && $stable(out_ac) && $stable(out_ov) && $stable(out_par));

  p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_par == ^out_res));

  p_incdec_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && incdec |=> out_cy == $past(in_cy) && out_ac == $past(in_ac)
      && out_ov == $past(in_ov));

  p_logic_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && keeps_all |=> out_cy == $past(in_cy) && out_ac == $past(in_ac)
      && out_ov == $past(in_ov));

  p_rlc_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && rot_c |=> out_cy == $past(in_acc[DW-1]) && out_res[0] == $past(in_cy));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd), .in_cy(in_cy),
  .in_ac(in_ac), .in_ov(in_ov), .out_valid(out_valid), .out_ready(out_ready),
  .out_res(out_res), .out_cy(out_cy), .out_ac(out_ac), .out_ov(out_ov),
  .out_par(out_par)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_acc = '0, in_opnd = '0;
  logic       in_cy = 1'b0, in_ac = 1'b0, in_ov = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;
  logic       out_cy, out_ac, out_ov, out_par;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd), .in_cy(in_cy),
    .in_ac(in_ac), .in_ov(in_ov), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_cy(out_cy), .out_ac(out_ac), .out_ov(out_ov),
    .out_par(out_par)
  );

  // {op, acc, opnd, cy ac ov in, result, cy ac ov par expected}
  localparam int NV = 30;
  localparam logic [34:0] VEC [NV] = '{
    {4'd0,  8'h3A, 8'h28, 3'b000, 8'h62, 4'b0101},
    {4'd0,  8'h7F, 8'h01, 3'b000, 8'h80, 4'b0111},
    {4'd0,  8'hFF, 8'h01, 3'b000, 8'h00, 4'b1100},
    {4'd0,  8'h80, 8'h80, 3'b000, 8'h00, 4'b1010},
    {4'd1,  8'h12, 8'h34, 3'b100, 8'h47, 4'b0000},
    {4'd1,  8'h0F, 8'h00, 3'b100, 8'h10, 4'b0101},
    {4'd2,  8'h50, 8'h20, 3'b000, 8'h30, 4'b0000},
    {4'd2,  8'h00, 8'h01, 3'b000, 8'hFF, 4'b1100},
    {4'd2,  8'h80, 8'h01, 3'b000, 8'h7F, 4'b0111},
    {4'd2,  8'h10, 8'h0F, 3'b100, 8'h00, 4'b0100},
    {4'd3,  8'hFF, 8'h00, 3'b101, 8'h00, 4'b1010},
    {4'd4,  8'h00, 8'h00, 3'b010, 8'hFF, 4'b0100},
    {4'd5,  8'hF0, 8'h3C, 3'b111, 8'h30, 4'b1110},
    {4'd6,  8'h0F, 8'hA0, 3'b000, 8'hAF, 4'b0000},
    {4'd7,  8'hFF, 8'h5A, 3'b100, 8'hA5, 4'b1000},
    {4'd8,  8'h5A, 8'h00, 3'b010, 8'hA5, 4'b0100},
    {4'd9,  8'h77, 8'h00, 3'b111, 8'h00, 4'b1110},
    {4'd10, 8'h3C, 8'h00, 3'b001, 8'hC3, 4'b0010},
    {4'd11, 8'h81, 8'h00, 3'b000, 8'h03, 4'b0000},
    {4'd12, 8'h99, 8'h00, 3'b000, 8'h32, 4'b1001},
    {4'd12, 8'h32, 8'h00, 3'b100, 8'h65, 4'b0000},
    {4'd13, 8'h66, 8'h00, 3'b100, 8'h33, 4'b1000},
    {4'd13, 8'h33, 8'h00, 3'b000, 8'h99, 4'b0000},
    {4'd14, 8'h01, 8'h00, 3'b011, 8'h00, 4'b1110},
    {4'd14, 8'h00, 8'h00, 3'b100, 8'h80, 4'b0001},
    {4'd15, 8'h7B, 8'h00, 3'b000, 8'h81, 4'b0000},
    {4'd15, 8'h12, 8'h00, 3'b010, 8'h18, 4'b0100},
    {4'd15, 8'hA0, 8'h00, 3'b000, 8'h00, 4'b1000},
    {4'd15, 8'h32, 8'h00, 3'b110, 8'h98, 4'b1101},
    {4'd15, 8'h9A, 8'h00, 3'b000, 8'h00, 4'b1000}
  };

  function automatic string tag_of(logic [3:0] op);
    if (op <= 4'd1) return "R1";
    if (op == 4'd2) return "R2";
    if (op <= 4'd4) return "R6";
    if (op <= 4'd10) return "R7";
    if (op <= 4'd14) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [2:0] f);
    in_op = op; in_acc = a; in_opnd = b;
    {in_cy, in_ac, in_ov} = f;
    in_valid = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R12", "in_ready in reset", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "out_valid after reset", {15'd0, out_valid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      drive(v[34:31], v[30:23], v[22:15], v[14:12]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(tag_of(v[34:31]), "result/carry", {7'd0, out_res, out_cy}, {7'd0, v[11:3]});
      check("R4", "aux carry", {15'd0, out_ac}, {15'd0, v[2]});
      check("R3", "overflow", {15'd0, out_ov}, {15'd0, v[1]});
      check("R5", "parity", {15'd0, out_par}, {15'd0, v[0]});
    end

    // R10: latency of one edge, then drain
    @(negedge clk);
    drive(4'd0, 8'h05, 8'h06, 3'b000);
    #1;
    check("R10", "no early valid", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "valid after accept", {7'd0, out_valid, out_res}, {7'd0, 1'b1, 8'h0B});
    @(negedge clk);
    check("R10", "valid drops after consume", {15'd0, out_valid}, 16'd0);

    // R11: back-pressure holds response and blocks input
    out_ready = 1'b0;
    drive(4'd0, 8'h01, 8'h02, 3'b000);
    @(negedge clk);
    drive(4'd0, 8'h10, 8'h20, 3'b000);
    repeat (3) @(negedge clk);
    check("R11", "in_ready low in stall", {15'd0, in_ready}, 16'd0);
    check("R11", "held response", {6'd0, out_valid, out_res, out_par}, {6'd0, 1'b1, 8'h03, 1'b0});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "queued request after release", {7'd0, out_valid, out_res}, {7'd0, 1'b1, 8'h30});
    @(negedge clk);
    check("R11", "empty after drain", {15'd0, out_valid}, 16'd0);

    // R12: reset clears a pending response
    out_ready = 1'b0;
    drive(4'd3, 8'h41, 8'h00, 3'b000);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12", "reset clears response", {14'd0, out_valid, in_ready}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule